// File: doc/BRIEF.md
# Delay-Loop Lock and Impedance Readiness Sequencer

This block keeps track of two readiness conditions inside a synchronous memory device: whether the clock-alignment loop has locked, and whether the output-driver impedance calibration has settled. Both are modelled with digital counters. The analog circuits are not modelled. The lock side counts command-clock edges while the loop is enabled. It restarts when the loop is disabled, when a frequency change is requested, or when the command clock stops long enough that the loop would lose its phase.

Clock absence is measured from a fast free-running reference clock. A toggle driven by the command clock is resynchronised into the reference domain. The block counts the reference ticks that pass without a toggle, and a full count of STOP_TICKS raises an internal stall condition. That condition clears the lock state at once, without waiting for a command-clock edge, so the lock flag falls while the clock is still stopped.

The impedance side counts command-clock cycles in which no read drives the outputs. A periodic update request is only released as a strobe in such a cycle. A request that meets a read is held back until a non-read cycle arrives.

Top module: `clk_lock_ready_seq`

## Requirements
- R1: While rst_n is low at a command-clock edge, lock_ready, imp_ready and imp_upd are all low after that edge.
- R2: A command-clock edge with loop_en low clears the lock count, and lock_ready is low after it.
- R3: lock_ready rises after the LOCK_CYCLES-th consecutive command-clock edge with loop_en high and freq_chg low (1024 by default), not one edge earlier. It then stays high while those conditions last.
- R4: A command-clock edge with freq_chg high clears the lock count. Another LOCK_CYCLES qualifying edges are then needed before lock_ready rises.
- R5: If no command-clock edge arrives for STOP_TICKS reference periods, lock_ready falls without any command-clock edge. The first command-clock edge after the clock returns is absorbed by the lock reset, and counting resumes on the edge after it.
- R6: imp_ready rises once IMP_CYCLES non-read edges (rd_cycle low) have been counted since reset, and then stays high. loop_en, freq_chg and clock stops have no effect on it.
- R7: An edge with rd_cycle high neither advances nor clears the non-read count. A read only delays imp_ready.
- R8: Every UPD_PERIOD command-clock edges an update request is set. imp_upd is high in any cycle where a request is pending and rd_cycle is low. That edge retires the request, unless a new period ends on the same edge, in which case the request stays set.
- R9: imp_upd is never high in a cycle with rd_cycle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; may be stopped |
| ref_clk | input | 1 | Fast free-running reference used to detect clock absence |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_en | input | 1 | Loop enable; low bypasses the loop |
| freq_chg | input | 1 | Frequency-change request, one cycle per request |
| rd_cycle | input | 1 | High in cycles whose read drives the outputs |
| lock_ready | output | 1 | Loop lock reached |
| imp_ready | output | 1 | Impedance calibration settled |
| imp_upd | output | 1 | Impedance update strobe, non-read cycles only |

## Verification
The bench keeps both count limits at their full value of 1024. This lets it check the exact edge on which each flag rises, after a fresh enable, after a frequency change and after a clock stop. STOP_TICKS is set to 15 against a 2 ns reference, which is a 30 ns absence window. A 200 ns clock stop therefore crosses it clearly, while the normal 20 ns edge spacing stays well inside it. UPD_PERIOD is cut to 16, so many update requests occur in a short run. Some of them meet read bursts and must be deferred, and steady non-read stretches give an exact strobe count per window.

// File: rtl/clk_lock_ready_seq.sv
`timescale 1ns/1ps
module clk_lock_ready_seq #(
  parameter int LOCK_CYCLES = 1024,
  parameter int IMP_CYCLES  = 1024,
  parameter int STOP_TICKS  = 30,
  parameter int UPD_PERIOD  = 64
) (
  input  logic clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic freq_chg,
  input  logic rd_cycle,
  output logic lock_ready,
  output logic imp_ready,
  output logic imp_upd
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int IW = $clog2(IMP_CYCLES + 1);
  localparam int SW = $clog2(STOP_TICKS + 1);
  localparam int TW = $clog2(UPD_PERIOD);

  logic          beat;
  logic [2:0]    beat_sync;
  logic [SW-1:0] idle_cnt;
  logic          stalled;
  logic [LW-1:0] lock_cnt;
  logic [IW-1:0] imp_cnt;
  logic [TW-1:0] upd_tmr;
  logic          upd_tick;
  logic          upd_pend;

  always_ff @(posedge clk)
    beat <= rst_n ? ~beat : 1'b0;

  always_ff @(posedge ref_clk)
    if (!rst_n) beat_sync <= '0;
    else        beat_sync <= {beat_sync[1:0], beat};

  always_ff @(posedge ref_clk)
    if (!rst_n || (beat_sync[2] ^ beat_sync[1])) idle_cnt <= '0;
    else if (!stalled)                           idle_cnt <= idle_cnt + SW'(1);

  assign stalled = (idle_cnt == SW'(STOP_TICKS));

  always_ff @(posedge clk or posedge stalled)
    if (stalled)                             lock_cnt <= '0;
    else if (!rst_n || !loop_en || freq_chg) lock_cnt <= '0;
    else if (!lock_ready)                    lock_cnt <= lock_cnt + LW'(1);

  assign lock_ready = (lock_cnt == LW'(LOCK_CYCLES));

  always_ff @(posedge clk)
    if (!rst_n)                      imp_cnt <= '0;
    else if (!rd_cycle && !imp_ready) imp_cnt <= imp_cnt + IW'(1);

  assign imp_ready = (imp_cnt == IW'(IMP_CYCLES));

  assign upd_tick = (upd_tmr == TW'(UPD_PERIOD - 1));

  always_ff @(posedge clk)
    if (!rst_n)        upd_tmr <= '0;
    else if (upd_tick) upd_tmr <= '0;
    else               upd_tmr <= upd_tmr + TW'(1);

  always_ff @(posedge clk)
    if (!rst_n)        upd_pend <= 1'b0;
    else if (upd_tick) upd_pend <= 1'b1;
    else if (imp_upd)  upd_pend <= 1'b0;

  assign imp_upd = upd_pend & ~rd_cycle;
endmodule

module clk_lock_ready_chk (
  input logic clk,
  input logic ref_clk,
  input logic rst_n,
  input logic stalled,
  input logic loop_en,
  input logic freq_chg,
  input logic rd_cycle,
  input logic lock_ready,
  input logic imp_ready,
  input logic imp_upd,
  input logic upd_pend
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!lock_ready && !imp_ready && !upd_pend));

  a_r2_bypass_low: assert property (@(posedge clk) disable iff (!rst_n || stalled)
    !loop_en |=> !lock_ready);

  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n || stalled)
    (lock_ready && loop_en && !freq_chg) |=> lock_ready);

  a_r4_freq_relock: assert property (@(posedge clk) disable iff (!rst_n || stalled)
    freq_chg |=> !lock_ready);

  a_r5_stall_drop: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stalled |=> !lock_ready);

  a_r6_imp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    imp_ready |=> imp_ready);

  a_r8_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pend && rd_cycle) |=> upd_pend);

  a_r9_no_read_upd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cycle |-> !imp_upd);
endmodule

bind clk_lock_ready_seq clk_lock_ready_chk u_chk (
  .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .stalled(stalled),
  .loop_en(loop_en), .freq_chg(freq_chg), .rd_cycle(rd_cycle),
  .lock_ready(lock_ready), .imp_ready(imp_ready), .imp_upd(imp_upd),
  .upd_pend(upd_pend)
);

// File: tb/clk_lock_ready_seq_tb_top.sv
`timescale 1ns/1ps
module clk_lock_ready_seq_tb_top;
  localparam int LOCK = 1024;
  localparam int IMP  = 1024;
  localparam int STOP = 15;
  localparam int UPD  = 16;

  logic clk = 1'b0, ref_clk = 1'b0, clk_run = 1'b1;
  logic rst_n = 1'b0, loop_en = 1'b0, freq_chg = 1'b0, rd_cycle = 1'b0;
  logic lock_ready, imp_ready, imp_upd;

  int tests = 0, fails = 0, nr = 0;
  int m_lock = 0, m_imp = 0, m_tmr = 0;
  bit m_pend = 0, m_skip = 0;

  clk_lock_ready_seq #(.LOCK_CYCLES(LOCK), .IMP_CYCLES(IMP), .STOP_TICKS(STOP), .UPD_PERIOD(UPD)) dut_i (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .loop_en(loop_en), .freq_chg(freq_chg),
    .rd_cycle(rd_cycle), .lock_ready(lock_ready), .imp_ready(imp_ready), .imp_upd(imp_upd));

  always #1 ref_clk = ~ref_clk;
  initial forever begin
    #10;
    clk = clk_run ? ~clk : 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_imp = 0; m_tmr = 0; m_pend = 0; m_skip = 0;
    end else begin
      bit strobe, tick;
      if (m_skip) begin m_skip = 0; m_lock = 0; end
      else if (!loop_en || freq_chg) m_lock = 0;
      else if (m_lock < LOCK) m_lock++;
      if (!rd_cycle && m_imp < IMP) m_imp++;
      strobe = m_pend && !rd_cycle;
      tick = (m_tmr == UPD - 1);
      m_tmr = tick ? 0 : m_tmr + 1;
      if (tick) m_pend = 1;
      else if (strobe) m_pend = 0;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic rd, input logic en, input logic fc);
    @(negedge clk);
    if (rst_n && !rd_cycle) nr++;
    rd_cycle = rd; loop_en = en; freq_chg = fc;
    #5;
    chk(lock_ready, m_lock == LOCK, en ? "R3" : "R2", "lock_ready model");
    chk(imp_ready, m_imp == IMP, "R6", "imp_ready model");
    chk(imp_ready, nr >= IMP, "R7", "imp_ready non-read count");
    chk(imp_upd, m_pend && !rd, "R8", "imp_upd model");
    if (rd) chk(imp_upd, 1'b0, "R9", "imp_upd in read cycle");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int strobes;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0);
    chk(lock_ready, 1'b0, "R1", "lock_ready in reset");
    chk(imp_ready, 1'b0, "R1", "imp_ready in reset");
    chk(imp_upd, 1'b0, "R1", "imp_upd in reset");
    rst_n = 1'b1;

    for (int i = 0; i < 50; i++) begin
      step(i % 7 == 0, 1'b0, 1'b0);
      chk(lock_ready, 1'b0, "R2", "lock_ready while bypassed");
    end

    for (int i = 1; i <= 1030; i++) begin
      step(i % 4 == 0, 1'b1, 1'b0);
      if (i == 1024) chk(lock_ready, 1'b0, "R3", "lock_ready one edge early");
      if (i == 1025) chk(lock_ready, 1'b1, "R3", "lock_ready on 1024th edge");
    end

    step(1'b0, 1'b1, 1'b1);
    chk(lock_ready, 1'b1, "R4", "lock_ready before change edge");
    for (int i = 1; i <= 1030; i++) begin
      step(i % 3 == 0, 1'b1, 1'b0);
      if (i == 1)    chk(lock_ready, 1'b0, "R4", "lock_ready after change");
      if (i == 1024) chk(lock_ready, 1'b0, "R4", "relock one edge early");
      if (i == 1025) chk(lock_ready, 1'b1, "R4", "relock on 1024th edge");
    end

    clk_run = 1'b0;
    m_lock = 0; m_skip = 1;
    #100;
    chk(lock_ready, 1'b0, "R5", "lock_ready during clock stop");
    chk(imp_ready, nr >= IMP, "R6", "imp_ready during clock stop");
    #100;
    clk_run = 1'b1;
    for (int i = 1; i <= 1030; i++) begin
      step(i % 5 == 0, 1'b1, 1'b0);
      if (i == 1)    chk(lock_ready, 1'b0, "R5", "lock_ready after restart");
      if (i == 1024) chk(lock_ready, 1'b0, "R5", "relock after stop early");
      if (i == 1025) chk(lock_ready, 1'b1, "R5", "relock after stop on time");
    end

    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0);
    strobes = 0;
    for (int i = 0; i < 64; i++) begin
      step(1'b0, 1'b1, 1'b0);
      if (imp_upd) strobes++;
    end
    chk(strobes == 4, 1'b1, "R8", "strobes per 64 non-read cycles is 4");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule